// File: doc/BRIEF.md
# Recorder Print Sequencer and Column Formatter

This block drives the fixed columns of a parallel BCD printer and decides when the printer may print. It turns a 3-bit measurement-unit code into two columns: an exponent sign and an exponent magnitude. It also produces an overflow column, which shows the asterisk code while the overflow flag is set. All three columns are registered one cycle behind their inputs.

A print request is not passed to the printer straight away. A rising edge of the request arms a small sequencer. The sequencer first waits for a display scan that starts after the request. It then waits for that scan to complete. Only then does it pulse the print command for one cycle, so the digit latches already hold fresh data when the printer acts.

An abort input cancels a pending request. A second request that arrives while one is pending is dropped. A parameter selects negative-logic outputs, where a logical 1 is driven low, so the columns can feed the printer directly.

Top module: `rec_print_fmt`

## Requirements
- R1: While `rstN` is low and after it is released, before any clock edge has loaded new data, the logical sign column is 4'hB, the logical magnitude and overflow columns are 4'h0, and the logical print command is 0.
- R2: With `INVERT_OUT`=1 (the default), every output bit is the complement of its logical value, so a logical 1 is driven as 0.
- R3: One cycle after `unitCode` is 1, 2 or 3 (Hz, kHz, MHz), the logical sign column is 4'hA (plus) and the logical magnitude is 0, 3 or 6, in that order.
- R4: One cycle after `unitCode` is 4, 5 or 6 (s, ms, µs), the logical sign column is 4'hB (minus) and the logical magnitude is 0, 3 or 6, in that order.
- R5: One cycle after `unitCode` is 0 (no units) or 7 (undefined), the logical sign column is 4'hB and the logical magnitude is 0.
- R6: One cycle after `overflowIn` is high, the logical overflow column is 4'hF (asterisk). When `overflowIn` is low, it is 4'h0.
- R7: A rising edge of `printReq` seen while idle arms a print. Only a `scanStart` in a later cycle moves the print on. The next `scanDone` after that releases it. A `scanDone` before that start, or in the same cycle as that start, does not release it.
- R8: The logical print command is high for exactly one cycle. That cycle directly follows the cycle in which the releasing `scanDone` was sampled.
- R9: `abortIn` high while a print is armed cancels it. This holds in the same cycle as the releasing `scanDone`, and in the same cycle as the request edge. No print command follows until a new request arrives.
- R10: A request edge while a print is armed is ignored. A request held high produces only one print command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| unitCode | input | UNIT_W | Measurement unit: 0 none, 1 Hz, 2 kHz, 3 MHz, 4 s, 5 ms, 6 µs |
| overflowIn | input | 1 | Overflow indicator |
| printReq | input | 1 | Print request, active on its rising edge |
| scanStart | input | 1 | One-cycle pulse when a display scan begins |
| scanDone | input | 1 | One-cycle pulse when a display scan completes |
| abortIn | input | 1 | Cancels an armed print request |
| signCol | output | COL_W | Exponent sign column |
| magCol | output | COL_W | Exponent magnitude column |
| ovfCol | output | COL_W | Overflow column |
| printCmd | output | 1 | Print command to the recorder |

## Verification
Some properties are checked on every cycle. The print command never lasts two cycles, it appears only right after a sampled `scanDone`, and it never follows a cycle with `abortIn` high. The column encodings for frequency, no-unit and undefined codes, and the overflow column, are also checked against the inputs of the previous cycle.

Other behaviour can only be shown by the bench scenarios, because it depends on history. These cases are: the order of request, scan start and scan completion; a `scanDone` that comes too early; a start and a completion in the same cycle; dropping a repeated or held request; and cancellation at each point of the sequence.

// File: rtl/rec_print_pkg.sv
package rec_print_pkg;

  localparam int UNIT_NONE = 0;
  localparam int UNIT_HZ   = 1;
  localparam int UNIT_KHZ  = 2;
  localparam int UNIT_MHZ  = 3;
  localparam int UNIT_SEC  = 4;
  localparam int UNIT_MSEC = 5;
  localparam int UNIT_USEC = 6;

  localparam int CODE_PLUS     = 10;
  localparam int CODE_MINUS    = 11;
  localparam int CODE_ASTERISK = 15;

  typedef enum logic [1:0] {
    SEQ_IDLE       = 2'd0,
    SEQ_WAIT_START = 2'd1,
    SEQ_WAIT_END   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic fire;
  } seqStrobe_t;

endpackage

// File: rtl/rec_print_seq.sv
module rec_print_seq
  import rec_print_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       printReq,
  input  logic       scanStart,
  input  logic       scanDone,
  input  logic       abortIn,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;
  logic      reqQ;
  logic      reqEdge;
  logic      fireNext;

  assign reqEdge = printReq & ~reqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      reqQ  <= 1'b0;
    end else begin
      state <= stateNext;
      reqQ  <= printReq;
    end
  end

  always_comb begin
    stateNext = state;
    fireNext  = 1'b0;
    case (state)
      SEQ_IDLE: begin
        if (reqEdge && !abortIn) stateNext = SEQ_WAIT_START;
      end
      SEQ_WAIT_START: begin
        if (abortIn)        stateNext = SEQ_IDLE;
        else if (scanStart) stateNext = SEQ_WAIT_END;
      end
      SEQ_WAIT_END: begin
        if (abortIn) begin
          stateNext = SEQ_IDLE;
        end else if (scanDone) begin
          stateNext = SEQ_IDLE;
          fireNext  = 1'b1;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  assign strobe.fire = fireNext;

endmodule

// File: rtl/rec_col_path.sv
module rec_col_path
  import rec_print_pkg::*;
#(
  parameter int UNIT_W     = 3,
  parameter int COL_W      = 4,
  parameter bit INVERT_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [UNIT_W-1:0] unitCode,
  input  logic              overflowIn,
  input  seqStrobe_t        strobe,
  output logic [COL_W-1:0]  signCol,
  output logic [COL_W-1:0]  magCol,
  output logic [COL_W-1:0]  ovfCol,
  output logic              printCmd
);

  localparam logic [COL_W-1:0] SIGN_PLUS  = COL_W'(CODE_PLUS);
  localparam logic [COL_W-1:0] SIGN_MINUS = COL_W'(CODE_MINUS);
  localparam logic [COL_W-1:0] ASTERISK   = COL_W'(CODE_ASTERISK);
  localparam logic [COL_W-1:0] MAG_ZERO   = COL_W'(0);
  localparam logic [COL_W-1:0] MAG_THREE  = COL_W'(3);
  localparam logic [COL_W-1:0] MAG_SIX    = COL_W'(6);

  logic [COL_W-1:0] signNext, magNext, ovfNext;
  logic [COL_W-1:0] signQ, magQ, ovfQ;
  logic             cmdQ;

  always_comb begin
    signNext = SIGN_MINUS;
    magNext  = MAG_ZERO;
    case (unitCode)
      UNIT_W'(UNIT_HZ):   begin signNext = SIGN_PLUS;  magNext = MAG_ZERO;  end
      UNIT_W'(UNIT_KHZ):  begin signNext = SIGN_PLUS;  magNext = MAG_THREE; end
      UNIT_W'(UNIT_MHZ):  begin signNext = SIGN_PLUS;  magNext = MAG_SIX;   end
      UNIT_W'(UNIT_SEC):  begin signNext = SIGN_MINUS; magNext = MAG_ZERO;  end
      UNIT_W'(UNIT_MSEC): begin signNext = SIGN_MINUS; magNext = MAG_THREE; end
      UNIT_W'(UNIT_USEC): begin signNext = SIGN_MINUS; magNext = MAG_SIX;   end
      default:            begin signNext = SIGN_MINUS; magNext = MAG_ZERO;  end
    endcase
    ovfNext = overflowIn ? ASTERISK : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signQ <= SIGN_MINUS;
      magQ  <= MAG_ZERO;
      ovfQ  <= '0;
      cmdQ  <= 1'b0;
    end else begin
      signQ <= signNext;
      magQ  <= magNext;
      ovfQ  <= ovfNext;
      cmdQ  <= strobe.fire;
    end
  end

  generate
    if (INVERT_OUT) begin : g_negLogic
      assign signCol  = ~signQ;
      assign magCol   = ~magQ;
      assign ovfCol   = ~ovfQ;
      assign printCmd = ~cmdQ;
    end else begin : g_posLogic
      assign signCol  = signQ;
      assign magCol   = magQ;
      assign ovfCol   = ovfQ;
      assign printCmd = cmdQ;
    end
  endgenerate

endmodule

// File: rtl/rec_print_fmt.sv
module rec_print_fmt
  import rec_print_pkg::*;
#(
  parameter int UNIT_W     = 3,
  parameter int COL_W      = 4,
  parameter bit INVERT_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [UNIT_W-1:0] unitCode,
  input  logic              overflowIn,
  input  logic              printReq,
  input  logic              scanStart,
  input  logic              scanDone,
  input  logic              abortIn,
  output logic [COL_W-1:0]  signCol,
  output logic [COL_W-1:0]  magCol,
  output logic [COL_W-1:0]  ovfCol,
  output logic              printCmd
);

  seqStrobe_t strobe;

  rec_print_seq u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .printReq  (printReq),
    .scanStart (scanStart),
    .scanDone  (scanDone),
    .abortIn   (abortIn),
    .strobe    (strobe)
  );

  rec_col_path #(
    .UNIT_W     (UNIT_W),
    .COL_W      (COL_W),
    .INVERT_OUT (INVERT_OUT)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .unitCode   (unitCode),
    .overflowIn (overflowIn),
    .strobe     (strobe),
    .signCol    (signCol),
    .magCol     (magCol),
    .ovfCol     (ovfCol),
    .printCmd   (printCmd)
  );

endmodule

// File: rtl/rec_print_fmt_chk.sv
module rec_print_fmt_chk #(
  parameter int UNIT_W     = 3,
  parameter int COL_W      = 4,
  parameter bit INVERT_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [UNIT_W-1:0] unitCode,
  input logic              overflowIn,
  input logic              scanDone,
  input logic              abortIn,
  input logic [COL_W-1:0]  signCol,
  input logic [COL_W-1:0]  magCol,
  input logic [COL_W-1:0]  ovfCol,
  input logic              printCmd
);

  logic [COL_W-1:0] signL, magL, ovfL;
  logic             cmdL;
  logic             seen;

  assign signL = INVERT_OUT ? ~signCol : signCol;
  assign magL  = INVERT_OUT ? ~magCol  : magCol;
  assign ovfL  = INVERT_OUT ? ~ovfCol  : ovfCol;
  assign cmdL  = INVERT_OUT ? ~printCmd : printCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  p_freq_plus_r3: assert property (@(posedge clk) disable iff (!rstN)
    seen && ($past(unitCode) == UNIT_W'(1) || $past(unitCode) == UNIT_W'(2) ||
             $past(unitCode) == UNIT_W'(3)) |-> signL == COL_W'(10));

  p_time_minus_r4: assert property (@(posedge clk) disable iff (!rstN)
    seen && ($past(unitCode) == UNIT_W'(4) || $past(unitCode) == UNIT_W'(5) ||
             $past(unitCode) == UNIT_W'(6)) |-> signL == COL_W'(11));

  p_default_unit_r5: assert property (@(posedge clk) disable iff (!rstN)
    seen && ($past(unitCode) == UNIT_W'(0) || $past(unitCode) == UNIT_W'(7))
      |-> signL == COL_W'(11) && magL == '0);

  p_ovf_col_r6: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> ovfL == ($past(overflowIn) ? COL_W'(15) : COL_W'(0)));

  p_cmd_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdL |=> !cmdL);

  p_cmd_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdL |-> seen && $past(scanDone));

  p_abort_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> !cmdL);

endmodule

bind rec_print_fmt rec_print_fmt_chk #(
  .UNIT_W     (UNIT_W),
  .COL_W      (COL_W),
  .INVERT_OUT (INVERT_OUT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .unitCode   (unitCode),
  .overflowIn (overflowIn),
  .scanDone   (scanDone),
  .abortIn    (abortIn),
  .signCol    (signCol),
  .magCol     (magCol),
  .ovfCol     (ovfCol),
  .printCmd   (printCmd)
);

// File: tb/tb_rec_print_fmt.sv
module tb_rec_print_fmt;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT_W = 3;
  localparam int COL_W  = 4;

  typedef struct {
    logic [COL_W-1:0] sign;
    logic [COL_W-1:0] mag;
    logic [COL_W-1:0] ovf;
    logic             cmd;
    string            tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [UNIT_W-1:0] unitCode = '0;
  logic              overflowIn = 1'b0;
  logic              printReq = 1'b0;
  logic              scanStart = 1'b0;
  logic              scanDone = 1'b0;
  logic              abortIn = 1'b0;
  logic [COL_W-1:0]  signCol, magCol, ovfCol;
  logic              printCmd;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [UNIT_W-1:0] uCur = '0;
  logic              oCur = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rec_print_fmt #(.UNIT_W(UNIT_W), .COL_W(COL_W), .INVERT_OUT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .unitCode(unitCode), .overflowIn(overflowIn),
    .printReq(printReq), .scanStart(scanStart), .scanDone(scanDone),
    .abortIn(abortIn), .signCol(signCol), .magCol(magCol), .ovfCol(ovfCol),
    .printCmd(printCmd)
  );

  // Expected driven levels per R2..R6 (negative logic: complement)
  function automatic expItem_t model(logic [UNIT_W-1:0] u, logic o, logic c, string t);
    expItem_t e;
    logic [COL_W-1:0] s, m;
    case (u)
      3'd1: begin s = 4'hA; m = 4'd0; end
      3'd2: begin s = 4'hA; m = 4'd3; end
      3'd3: begin s = 4'hA; m = 4'd6; end
      3'd4: begin s = 4'hB; m = 4'd0; end
      3'd5: begin s = 4'hB; m = 4'd3; end
      3'd6: begin s = 4'hB; m = 4'd6; end
      default: begin s = 4'hB; m = 4'd0; end
    endcase
    e.sign = ~s;
    e.mag  = ~m;
    e.ovf  = ~(o ? 4'hF : 4'h0);
    e.cmd  = ~c;
    e.tag  = t;
    return e;
  endfunction

  task automatic compareNow(expItem_t e);
    compared++;
    if (signCol !== e.sign || magCol !== e.mag || ovfCol !== e.ovf || printCmd !== e.cmd) begin
      mismatched++;
      $display("FAIL %s: got sign=%h mag=%h ovf=%h cmd=%b expected sign=%h mag=%h ovf=%h cmd=%b",
               e.tag, signCol, magCol, ovfCol, printCmd, e.sign, e.mag, e.ovf, e.cmd);
    end
  endtask

  // Driver: one cycle of stimulus, expected outputs after the next edge
  task automatic cyc(logic req, logic st, logic dn, logic ab, logic expCmd, string tag);
    @(negedge clk);
    unitCode   = uCur;
    overflowIn = oCur;
    printReq   = req;
    scanStart  = st;
    scanDone   = dn;
    abortIn    = ab;
    expQ.push_back(model(uCur, oCur, expCmd, tag));
  endtask

  // Monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) compareNow(expQ.pop_front());
    end
  end

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    endRun();
  end

  initial begin
    // R1 / R2: reset state at the pins, while in reset
    repeat (3) @(posedge clk);
    #1;
    compareNow(model(3'd0, 1'b0, 1'b0, "R1 reset held"));
    @(negedge clk);
    rstN = 1'b1;
    #1;
    compareNow(model(3'd0, 1'b0, 1'b0, "R1 after release"));

    // R3, R4, R5, R6, R2: unit sweep with overflow toggling
    for (int u = 0; u < 8; u++) begin
      uCur = UNIT_W'(u);
      oCur = u[0];
      cyc(0, 0, 0, 0, 0, (u >= 1 && u <= 3) ? "R3 freq unit" :
                         (u >= 4 && u <= 6) ? "R4 time unit" : "R5 default unit");
    end
    oCur = 1'b1;
    cyc(0, 0, 0, 0, 0, "R6 overflow set");
    oCur = 1'b0;
    uCur = 3'd2;
    cyc(0, 0, 0, 0, 0, "R6 overflow clear");

    // R7 / R8: basic sequence, early done ignored
    cyc(1, 0, 0, 0, 0, "R7 request");
    cyc(0, 0, 1, 0, 0, "R7 done before start");
    cyc(0, 1, 0, 0, 0, "R7 start");
    cyc(0, 0, 0, 0, 0, "R7 mid scan");
    cyc(0, 0, 1, 0, 1, "R8 print pulse");
    cyc(0, 0, 0, 0, 0, "R8 pulse one cycle");
    cyc(0, 1, 0, 0, 0, "R8 idle scan");
    cyc(0, 0, 1, 0, 0, "R8 no repeat");

    // R7: start in same cycle as request does not count
    uCur = 3'd5;
    cyc(1, 1, 0, 0, 0, "R7 start with request");
    cyc(0, 0, 1, 0, 0, "R7 done not armed");
    cyc(0, 1, 0, 0, 0, "R7 later start");
    cyc(0, 0, 1, 0, 1, "R7 print after later start");
    cyc(0, 0, 0, 0, 0, "R8 back low");

    // R7: start and done together in wait-start state
    cyc(1, 0, 0, 0, 0, "R7 request");
    cyc(0, 1, 1, 0, 0, "R7 start+done same cycle");
    cyc(0, 0, 1, 0, 1, "R7 print on next done");
    cyc(0, 0, 0, 0, 0, "R8 back low");

    // R9: abort during scan
    oCur = 1'b1;
    cyc(1, 0, 0, 0, 0, "R9 request");
    cyc(0, 1, 0, 0, 0, "R9 start");
    cyc(0, 0, 0, 1, 0, "R9 abort mid scan");
    cyc(0, 0, 1, 0, 0, "R9 done after abort");
    cyc(0, 1, 0, 0, 0, "R9 start after abort");
    cyc(0, 0, 1, 0, 0, "R9 still cancelled");

    // R9: abort before start
    cyc(1, 0, 0, 0, 0, "R9 request");
    cyc(0, 0, 0, 1, 0, "R9 abort before start");
    cyc(0, 1, 0, 0, 0, "R9 start");
    cyc(0, 0, 1, 0, 0, "R9 no print");

    // R9: abort with done
    cyc(1, 0, 0, 0, 0, "R9 request");
    cyc(0, 1, 0, 0, 0, "R9 start");
    cyc(0, 0, 1, 1, 0, "R9 abort with done");
    cyc(0, 0, 0, 0, 0, "R9 no print");

    // R9: abort with request edge
    cyc(1, 0, 0, 1, 0, "R9 abort with request");
    cyc(0, 1, 0, 0, 0, "R9 start");
    cyc(0, 0, 1, 0, 0, "R9 request dropped");

    // R10: second edge while pending ignored
    oCur = 1'b0;
    uCur = 3'd3;
    cyc(1, 0, 0, 0, 0, "R10 request");
    cyc(0, 0, 0, 0, 0, "R10 drop");
    cyc(1, 0, 0, 0, 0, "R10 second edge");
    cyc(0, 1, 0, 0, 0, "R10 start");
    cyc(0, 0, 1, 0, 1, "R10 single print");
    cyc(0, 0, 0, 0, 0, "R10 low");
    cyc(0, 1, 0, 0, 0, "R10 start");
    cyc(0, 0, 1, 0, 0, "R10 second edge ignored");

    // R10: held request gives one print only
    cyc(1, 0, 0, 0, 0, "R10 held request");
    cyc(1, 1, 0, 0, 0, "R10 held start");
    cyc(1, 0, 1, 0, 1, "R10 held print");
    cyc(1, 1, 0, 0, 0, "R10 held start again");
    cyc(1, 0, 1, 0, 0, "R10 held no reprint");
    cyc(0, 0, 0, 0, 0, "R10 release");

    @(negedge clk);
    @(negedge clk);
    endRun();
  end

endmodule